// File: doc/BRIEF.md
# Glitch-Free Differential Clock Stop Controller

This block sits at the end of a clock distribution path. From one fast running clock it makes a common output phase that toggles on every cycle, and it drives four output channels from that phase. Each channel presents a true level, a complement level and an output-enable that goes to an analog pad driver. Two configuration bytes set which channels are enabled and which channels may be stopped. A mode bit chooses where a halted channel rests: driven, with true high and complement low, or released to high impedance.

An asynchronous active-low stop input passes through a synchroniser. While stop is active, every enabled channel marked stoppable finishes its current low phase and halts on its next rising transition. Channels marked free-run keep toggling. When stop is released, a halted channel is first driven to the high level. It then restarts on a falling transition of the common phase after a configurable number of phase periods, so no shortened high or low phase ever appears at the pad. A disabled channel halts in the same way whatever the stop input and its stoppable bit say. It stays halted until it is enabled again.

Top module: `diffclk_stop_ctrl`

## Requirements
- R1: A running channel toggles on every clock cycle (output period of two cycles), with output-enable 1 and complement equal to the inverse of true whenever output-enable is 1.
- R2: Channels 3, 2, 1 and 0 take their enable bit and their stoppable bit from bit positions 6, 5, 2 and 1 of the enable byte and the stoppable byte. Bits 0, 3, 4 and 7 of both bytes have no effect.
- R3: An enabled channel whose stoppable bit is 0 keeps toggling while stop is held low.
- R4: An enabled stoppable channel halts within four clock cycles after stop goes low, and the halt happens at a rising transition.
- R5: With the park mode bit at 0, a halted channel shows true 1, complement 0 and output-enable 1.
- R6: With the park mode bit at 1, a halted channel shows output-enable 0, with true and complement both at 0.
- R7: After stop is released, a halted enabled channel shows its first low phase between 4 and 12 clock cycles later (2 to 6 output periods, with the default of two restart periods).
- R8: In high-impedance park mode, a restarting channel is driven high (output-enable 1, true 1) for at least one cycle before its first low phase.
- R9: A channel whose enable bit is 0 is halted in the state the park mode bit selects, whatever the stop input and its stoppable bit are, and it stays halted after stop is released.
- R10: A driven low phase always lasts exactly one clock cycle, and all channels are low in the same cycles (phase-aligned).
- R11: While reset is held, every channel shows true 0, complement 1 and output-enable 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Running source clock |
| rst | input | 1 | Synchronous reset, active high |
| stop_n | input | 1 | Asynchronous stop request, active low |
| en_cfg | input | 8 | Channel enable byte (bits 6,5,2,1 = channels 3..0) |
| stoppable_cfg | input | 8 | Channel stoppable byte, same bit positions (1 = stoppable) |
| park_hiz | input | 1 | Park mode: 0 = driven high, 1 = high impedance |
| dif_p | output | 4 | True level per channel |
| dif_n | output | 4 | Complement level per channel |
| dif_oe | output | 4 | Pad driver enable per channel |

## Verification
The assertions assume that the enable byte, the stoppable byte and the park mode bit are quasi-static. They may change only between stop episodes, never as part of the halt or restart handshake. The stop input may change at any time, because it passes through the synchroniser. The stimulus sweeps every combination of the enable and stoppable masks in both park modes. It changes the configuration only while stop is released and the outputs have settled, and it toggles the reserved bits of both bytes between sweep passes.

// File: rtl/dstop_pkg.sv
package dstop_pkg;

    // Channel gating state
    typedef enum logic [1:0] {
        CH_RUN  = 2'd0,
        CH_PARK = 2'd1,
        CH_WAKE = 2'd2
    } ch_state_e;

    // Pad-facing drive of one channel
    typedef struct packed {
        logic p;
        logic n;
        logic oe;
    } ch_drive_t;

    // Decoded per-channel configuration
    typedef struct packed {
        logic enable;
        logic stoppable;
    } ch_cfg_t;

    // Bit position of a channel inside the configuration bytes
    function automatic int ch_bit_pos(input int ch);
        return (ch < 2) ? ch + 1 : ch + 3;
    endfunction

    function automatic ch_drive_t drive_run(input logic level);
        ch_drive_t d;
        d.p  = level;
        d.n  = ~level;
        d.oe = 1'b1;
        return d;
    endfunction

    function automatic ch_drive_t drive_park(input logic hiz);
        ch_drive_t d;
        d.p  = ~hiz;
        d.n  = 1'b0;
        d.oe = ~hiz;
        return d;
    endfunction

    function automatic ch_drive_t drive_high();
        ch_drive_t d;
        d.p  = 1'b1;
        d.n  = 1'b0;
        d.oe = 1'b1;
        return d;
    endfunction

endpackage

// File: rtl/dstop_sync.sv
module dstop_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/dstop_phase.sv
module dstop_phase (
    input  logic clk,
    input  logic rst,
    output logic phase_nxt
);
    logic phase_q;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= 1'b0;
        else     phase_q <= phase_nxt;
    end

    assign phase_nxt = ~phase_q;

    // R1: common phase flips on every cycle out of reset
    assert_phase_toggles_R1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (phase_q != $past(phase_q)));
endmodule

// File: rtl/dstop_cfg_decode.sv
module dstop_cfg_decode
    import dstop_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CFG_W  = 8
) (
    input  logic [CFG_W-1:0]             en_byte,
    input  logic [CFG_W-1:0]             stop_byte,
    output ch_cfg_t [NUM_CH-1:0]         cfg
);
    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{en_byte, stop_byte};

    for (genvar c = 0; c < NUM_CH; c++) begin : g_map
        localparam int POS = ch_bit_pos(c);
        assign cfg[c].enable    = en_byte[POS];
        assign cfg[c].stoppable = stop_byte[POS];
    end
endmodule

// File: rtl/dstop_channel.sv
module dstop_channel
    import dstop_pkg::*;
#(
    parameter int RESTART_PERIODS = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      phase_nxt,
    input  logic      halt_req,
    input  logic      park_hiz,
    output ch_drive_t drv
);
    localparam int CNT_W = (RESTART_PERIODS > 1) ? $clog2(RESTART_PERIODS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RESTART_PERIODS - 1);

    ch_state_e        state_q;
    logic [CNT_W-1:0] wake_cnt_q;
    ch_drive_t        drv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= CH_RUN;
            wake_cnt_q <= '0;
            drv_q      <= drive_run(1'b0);
        end else begin
            case (state_q)
                CH_RUN: begin
                    if (halt_req && phase_nxt) begin
                        state_q <= CH_PARK;
                        drv_q   <= drive_park(park_hiz);
                    end else begin
                        drv_q   <= drive_run(phase_nxt);
                    end
                end
                CH_PARK: begin
                    if (!halt_req) begin
                        state_q    <= CH_WAKE;
                        wake_cnt_q <= '0;
                        drv_q      <= drive_high();
                    end else begin
                        drv_q      <= drive_park(park_hiz);
                    end
                end
                CH_WAKE: begin
                    if (halt_req) begin
                        state_q <= CH_PARK;
                        drv_q   <= drive_park(park_hiz);
                    end else if (!phase_nxt) begin
                        if (wake_cnt_q == CNT_LAST) begin
                            state_q <= CH_RUN;
                            drv_q   <= drive_run(1'b0);
                        end else begin
                            wake_cnt_q <= wake_cnt_q + 1'b1;
                            drv_q      <= drive_high();
                        end
                    end else begin
                        drv_q <= drive_high();
                    end
                end
                default: begin
                    state_q <= CH_PARK;
                    drv_q   <= drive_park(park_hiz);
                end
            endcase
        end
    end

    assign drv = drv_q;

    // R10: a driven low phase ends after one cycle (high again or released)
    assert_low_one_cycle_R10: assert property (@(posedge clk) disable iff (rst)
        (drv_q.oe && !drv_q.p) |=> (drv_q.p || !drv_q.oe));

    // R10: every falling edge lines up with the common phase going low
    assert_fall_aligned_R10: assert property (@(posedge clk) disable iff (rst)
        (drv_q.oe && $fell(drv_q.p)) |-> !$past(phase_nxt));

    // R4: a halt is entered only on a rising transition of the phase
    assert_park_at_rise_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == CH_PARK && $past(state_q) == CH_RUN) |-> $past(phase_nxt));

    // R6: released pads carry no level
    assert_hiz_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !drv_q.oe |-> (!drv_q.p && !drv_q.n));

    // R8: restart leaves a driven-high state
    assert_wake_driven_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == CH_RUN && $past(state_q) == CH_WAKE) |-> ($past(drv_q.oe) && $past(drv_q.p)));
endmodule

// File: rtl/diffclk_stop_ctrl.sv
module diffclk_stop_ctrl
    import dstop_pkg::*;
#(
    parameter int NUM_CH          = 4,
    parameter int SYNC_STAGES     = 2,
    parameter int RESTART_PERIODS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stop_n,
    input  logic [7:0]        en_cfg,
    input  logic [7:0]        stoppable_cfg,
    input  logic              park_hiz,
    output logic [NUM_CH-1:0] dif_p,
    output logic [NUM_CH-1:0] dif_n,
    output logic [NUM_CH-1:0] dif_oe
);
    localparam int CFG_W = 8;

    logic                 stop_n_sync;
    logic                 phase_nxt;
    ch_cfg_t [NUM_CH-1:0] cfg;
    ch_drive_t [NUM_CH-1:0] drv;

    dstop_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (stop_n),
        .sync_out (stop_n_sync)
    );

    dstop_phase u_phase (
        .clk       (clk),
        .rst       (rst),
        .phase_nxt (phase_nxt)
    );

    dstop_cfg_decode #(
        .NUM_CH (NUM_CH),
        .CFG_W  (CFG_W)
    ) u_decode (
        .en_byte   (en_cfg),
        .stop_byte (stoppable_cfg),
        .cfg       (cfg)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic halt_req;
        assign halt_req = !cfg[c].enable || (cfg[c].stoppable && !stop_n_sync);

        dstop_channel #(
            .RESTART_PERIODS (RESTART_PERIODS)
        ) u_chan (
            .clk       (clk),
            .rst       (rst),
            .phase_nxt (phase_nxt),
            .halt_req  (halt_req),
            .park_hiz  (park_hiz),
            .drv       (drv[c])
        );

        assign dif_p[c]  = drv[c].p;
        assign dif_n[c]  = drv[c].n;
        assign dif_oe[c] = drv[c].oe;
    end
endmodule

// File: tb/diffclk_stop_ctrl_test.sv
module diffclk_stop_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           stop_n = 1'b1;
    logic [7:0]     en_cfg = 8'h00;
    logic [7:0]     stoppable_cfg = 8'h00;
    logic           park_hiz = 1'b0;
    logic [NCH-1:0] dif_p, dif_n, dif_oe;

    int n_checks = 0;
    int n_fails  = 0;
    int low_par  = -1;
    int cyc      = 0;
    bit done     = 0;
    logic [NCH-1:0] mon_prev_p  = '0;
    logic [NCH-1:0] mon_prev_oe = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    diffclk_stop_ctrl uut (
        .clk           (clk),
        .rst           (rst),
        .stop_n        (stop_n),
        .en_cfg        (en_cfg),
        .stoppable_cfg (stoppable_cfg),
        .park_hiz      (park_hiz),
        .dif_p         (dif_p),
        .dif_n         (dif_n),
        .dif_oe        (dif_oe)
    );

    task automatic check(input bit ok, input string req, input int ch,
                         input int actual, input int expected);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s ch%0d t=%0t actual=%0d expected=%0d", req, ch, $time, actual, expected);
        end
    endtask

    function automatic logic [7:0] pack_byte(input logic [3:0] mask, input logic [7:0] resv);
        logic [7:0] b;
        b = resv & 8'h99;
        for (int c = 0; c < NCH; c++) begin
            b[(c < 2) ? c + 1 : c + 3] = mask[c];
        end
        return b;
    endfunction

    // continuous pad monitor
    always @(negedge clk) begin
        if (!rst) begin
            cyc++;
            for (int c = 0; c < NCH; c++) begin
                if (mon_prev_oe[c] && !mon_prev_p[c])
                    check(dif_p[c] || !dif_oe[c], "R10", c, dif_p[c], 1);
                if (dif_oe[c])
                    check(dif_n[c] == !dif_p[c], "R1", c, dif_n[c], !dif_p[c]);
                else
                    check(!dif_p[c] && !dif_n[c], "R6", c, {dif_p[c], dif_n[c]}, 0);
                if (dif_oe[c] && !dif_p[c]) begin
                    if (low_par < 0) low_par = cyc % 2;
                    check((cyc % 2) == low_par, "R10", c, cyc % 2, low_par);
                end
            end
            mon_prev_p  = dif_p;
            mon_prev_oe = dif_oe;
        end
    end

    task automatic check_parked(input int c, input string req);
        if (park_hiz)
            check(!dif_oe[c] && !dif_p[c] && !dif_n[c], req == "" ? "R6" : req, c,
                  {dif_oe[c], dif_p[c], dif_n[c]}, 0);
        else
            check(dif_oe[c] && dif_p[c] && !dif_n[c], req == "" ? "R5" : req, c,
                  {dif_oe[c], dif_p[c], dif_n[c]}, 6);
    endtask

    task automatic check_modes(input int c);
        if (park_hiz) check_parked(c, "R6");
        else          check_parked(c, "R5");
    endtask

    task automatic run_config(input logic [3:0] en_m, input logic [3:0] st_m,
                              input logic hiz, input logic [7:0] resv);
        logic [NCH-1:0] p_a, oe_a;
        int  first_low [NCH];
        bit  drove_high [NCH];
        @(negedge clk);
        en_cfg        = pack_byte(en_m, resv);
        stoppable_cfg = pack_byte(st_m, ~resv);
        park_hiz      = hiz;
        stop_n        = 1'b1;
        repeat (12) @(negedge clk);
        // configuration applied, stop released
        p_a = dif_p; oe_a = dif_oe;
        @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            if (en_m[c]) begin
                check(oe_a[c] && dif_oe[c] && (p_a[c] != dif_p[c]), "R2", c, {p_a[c], dif_p[c]}, 1);
                check(p_a[c] != dif_p[c], "R1", c, dif_p[c], !p_a[c]);
            end else begin
                check_parked(c, "R9");
                check_parked(c, "R2");
            end
        end
        // stop asserted
        stop_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int c = 0; c < NCH; c++)
            if (en_m[c] && st_m[c]) check_parked(c, "R4");
        repeat (2) @(negedge clk);
        p_a = dif_p; oe_a = dif_oe;
        @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            if (en_m[c] && !st_m[c]) begin
                check(oe_a[c] && dif_oe[c] && (p_a[c] != dif_p[c]), "R3", c, {p_a[c], dif_p[c]}, 1);
            end else if (en_m[c]) begin
                check_modes(c);
            end else begin
                check_parked(c, "R9");
            end
        end
        // stop released
        stop_n = 1'b1;
        for (int c = 0; c < NCH; c++) begin
            first_low[c]  = -1;
            drove_high[c] = 0;
        end
        p_a = dif_p; oe_a = dif_oe;
        for (int j = 1; j <= 14; j++) begin
            @(negedge clk);
            for (int c = 0; c < NCH; c++) begin
                if (first_low[c] < 0 && dif_oe[c] && !dif_p[c]) begin
                    first_low[c]  = j;
                    drove_high[c] = oe_a[c] && p_a[c];
                end
            end
            p_a = dif_p; oe_a = dif_oe;
        end
        for (int c = 0; c < NCH; c++) begin
            if (en_m[c] && st_m[c]) begin
                check(first_low[c] >= 4 && first_low[c] <= 12, "R7", c, first_low[c], 5);
                if (hiz) check(drove_high[c], "R8", c, drove_high[c], 1);
            end else if (!en_m[c]) begin
                check(first_low[c] < 0, "R9", c, first_low[c], -1);
                check_parked(c, "R9");
            end
        end
    endtask

    initial begin
        en_cfg        = 8'hFF;
        stoppable_cfg = 8'h00;
        repeat (3) @(negedge clk);
        for (int c = 0; c < NCH; c++)
            check(!dif_p[c] && dif_n[c] && dif_oe[c], "R11", c,
                  {dif_p[c], dif_n[c], dif_oe[c]}, 3);
        rst = 1'b0;
        for (int pass = 0; pass < 2; pass++) begin
            for (int m = 0; m < 2; m++) begin
                for (int e = 0; e < 16; e++) begin
                    for (int s = 0; s < 16; s++) begin
                        if (pass == 0 || (e == 15 && (s % 5) == 0))
                            run_config(4'(e), 4'(s), 1'(m), pass ? 8'hFF : 8'h00);
                    end
                end
            end
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (80000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired: run did not complete, actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule